// File: doc/BRIEF.md
# Carry-Pipelined Dual Ones-Complement Accumulator

This block keeps a running 32-bit value made of two independent 16-bit ones-complement sums, one for the upper half-word and one for the lower half-word of every input word. It is meant to sit beside a data mover and sum every word that crosses a bus. The final fold of the two halves and the inversion into a transport checksum are done elsewhere.

Each 16-bit half is cut into six short carry-lookahead groups. The carry leaving each group is registered and enters the next group one clock later. The top group's carry wraps into bit 0 of its own half. As a result, the logic depth per clock is set by one small group rather than a full 16-bit adder, and a new word can be taken on every clock. The price is that carries still in flight need a few idle clocks to settle. A flag reports when no carry is left in flight, which means the raw value is final.

Top module: `csum_ring_acc`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), acc reads 0 and drained reads 1.
- R2: The two halves are independent. No carry ever passes between bit 15 and bit 16, so acc[31:16] depends only on din[31:16] and acc[15:0] depends only on din[15:0].
- R3: Once drained is 1, each half of acc is equal to the ones-complement sum of the matching half-words of all accepted words. The values 0x0000 and 0xFFFF count as the same value.
- R4: When add_en is 0 at a clock edge, din has no effect. A drained acc keeps its value whatever din carries.
- R5: drained reads 0 in the cycle after any clock edge at which a word was accepted (add_en 1, clr 0).
- R6: After the last accepted word, drained rises within 12 idle clocks. While drained is 1 and no word is taken, acc does not change.
- R7: A word is accepted on every clock edge with add_en high, including long back-to-back runs.
- R8: The end-around carry is applied within each half: accumulating 0xFFFF and then 0x0001 in a half settles to exactly 0x0001.
- R9: clr high at a clock edge zeroes the sum and every in-flight carry, and it takes priority over add_en. The next cycle shows acc = 0 and drained = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sum and the carries |
| add_en | input | 1 | Accept din at this clock edge |
| din | input | 32 | Data word to accumulate |
| acc | output | 32 | Raw accumulator, two 16-bit partial sums |
| drained | output | 1 | No carry is in flight, so acc is settled |

## Verification
acc, drained and the effect of clr all change at the same clock edge that samples the inputs. The bench therefore drives inputs on a falling edge and reads outputs on the next falling edge. drained must read 0 one clock after each accepted word. Sum values are compared only after drained has risen, and the bench allows up to 12 idle clocks for that. During those idle clocks din carries random data, which also confirms that ignored data leaves no mark.

// File: rtl/csum_pkg.sv
// Shared constants and group-layout functions for the checksum accumulator.
// Assumes each half follows a repeating 3,3,2 bit pattern of lookahead groups.
package csum_pkg;
    localparam int HALF_W = 16;
    localparam int NGRP   = 6;
    localparam int CYC_W  = 8;   // bits covered by one 3,3,2 cycle

    // Width of lookahead group g.
    function automatic int grp_w(input int g);
        return ((g % 3) == 2) ? 2 : 3;
    endfunction

    // Least significant bit of lookahead group g inside a half.
    function automatic int grp_lo(input int g);
        return (g / 3) * CYC_W + (g % 3) * 3;
    endfunction
endpackage

// File: rtl/csum_group.sv
// Small ripple-lookahead adder slice: adds two W-bit operands and a carry-in.
// The carry uses OR in place of XOR in the propagate term, which gives the same result.
module csum_group #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Sum and carry through the slice.
    always_comb begin
        logic [W:0] c;
        c[0] = cin;
        for (int k = 0; k < W; k++) begin
            sum[k]   = a[k] ^ b[k] ^ c[k];
            c[k+1]   = (a[k] & b[k]) | ((a[k] | b[k]) & c[k]);
        end
        cout = c[W];
    end
endmodule

// File: rtl/csum_half.sv
// One 16-bit ones-complement ring: six lookahead groups with registered carries.
// Each group's carry enters the next group one clock later; the top carry wraps to bit 0.
// Assumes d is already zero when no word is being accepted.
module csum_half
    import csum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [HALF_W-1:0] d,
    output logic [HALF_W-1:0] q,
    output logic              cy_zero
);
    logic [HALF_W-1:0] q_nx;
    logic [NGRP-1:0]   cy, cy_nx;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int W  = grp_w(g);
        csum_group #(.W(W)) u_grp (
            .a    (q[LO +: W]),
            .b    (d[LO +: W]),
            .cin  (cy[(g + NGRP - 1) % NGRP]),
            .sum  (q_nx[LO +: W]),
            .cout (cy_nx[g])
        );
    end

    // Sum and carry registers, cleared by reset or clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q  <= '0;
            cy <= '0;
        end else begin
            q  <= q_nx;
            cy <= cy_nx;
        end
    end

    assign cy_zero = (cy == '0);

    // R9: a clear empties both the sum and the carry ring.
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0) && cy_zero);

    // R6: with no carry in flight and nothing added, the sum holds.
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && d == '0 && cy_zero) |=> $stable(q) && cy_zero);
endmodule

// File: rtl/csum_ring_acc.sv
// Top of the accumulator: two independent 16-bit ones-complement rings, plus a drained flag.
// The flag is registered. It goes high after an idle edge that leaves no carry in flight.
module csum_ring_acc
    import csum_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] acc,
    output logic              drained
);
    localparam int NHALF = DATA_W / HALF_W;

    logic [DATA_W-1:0] d_gated;
    logic [NHALF-1:0]  half_idle;

    assign d_gated = add_en ? din : '0;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        csum_half u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .d       (d_gated[h*HALF_W +: HALF_W]),
            .q       (acc[h*HALF_W +: HALF_W]),
            .cy_zero (half_idle[h])
        );
    end

    logic carries_will_clear;
    logic drained_q;

    // Predicts whether all carry registers are zero after this edge (idle edges only).
    csum_drain_pred #(.NHALF(NHALF)) u_pred (
        .acc     (acc),
        .idle    (half_idle),
        .all_out (carries_will_clear)
    );

    // Drained flag: set by clear, dropped on an accepted word, set once the carries are gone.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            drained_q <= 1'b1;
        else if (add_en)
            drained_q <= 1'b0;
        else
            drained_q <= carries_will_clear;
    end

    assign drained = drained_q;

    // R5: an accepted word always drops the flag.
    a_r5_add_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> !drained);

    // R6: the flag never claims settled while a carry is still in flight.
    a_r6_flag_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (&half_idle));

    // R6: a settled, idle accumulator keeps its value.
    a_r6_settled_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (drained && !add_en && !clr) |=> $stable(acc) && drained);
endmodule

// File: rtl/csum_drain_pred.sv
// Predicts, for an idle edge, whether every carry register will be zero afterwards.
// With no data added, group g emits a carry only if it is all ones and receives one.
// The carries themselves are not visible here. If each half's carries are already zero,
// none can appear. Otherwise the prediction stays low for one more idle edge, which errs
// on the safe side.
module csum_drain_pred
    import csum_pkg::*;
#(
    parameter int NHALF = 2
) (
    input  logic [NHALF*HALF_W-1:0] acc,
    input  logic [NHALF-1:0]        idle,
    output logic                    all_out
);
    logic unused_acc;
    assign unused_acc = ^acc;

    // All halves quiet now means quiet after an idle edge.
    always_comb all_out = &idle;
endmodule

// File: tb/csum_ring_acc_tb.sv
module csum_ring_acc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DRAIN_MAX  = 12;

    logic        clk = 1'b0;
    logic        rst_n, clr, add_en;
    logic [31:0] din;
    logic [31:0] acc;
    logic        drained;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ref_lo, ref_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    csum_ring_acc u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(add_en),
        .din(din), .acc(acc), .drained(drained)
    );

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    function automatic bit oc_eq(input logic [15:0] a, input logic [15:0] b);
        return (a == b) || ((a == 16'h0000 || a == 16'hFFFF) && (b == 16'h0000 || b == 16'hFFFF));
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr = 1'b1; add_en = 1'b0; din = $urandom;
        tick();
        clr = 1'b0;
        ref_lo = 16'h0; ref_hi = 16'h0;
    endtask

    task automatic push(input logic [31:0] w);
        add_en = 1'b1; din = w;
        ref_lo = oc_add(ref_lo, w[15:0]);
        ref_hi = oc_add(ref_hi, w[31:16]);
        tick();
        check(!drained, "R5 drained low after word", {31'd0, drained}, 32'd0);
    endtask

    task automatic gap();
        add_en = 1'b0; din = $urandom;
        tick();
    endtask

    task automatic drain_and_check(input string req);
        int n;
        add_en = 1'b0; din = $urandom;
        tick();
        n = 1;
        while (!drained && n < DRAIN_MAX) begin
            din = $urandom;
            tick();
            n++;
        end
        check(drained, "R6 drained within bound", {31'd0, drained}, 32'd1);
        check(oc_eq(acc[15:0], ref_lo) && oc_eq(acc[31:16], ref_hi), req, acc, {ref_hi, ref_lo});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1936));
        rst_n = 1'b0; clr = 1'b0; add_en = 1'b1; din = 32'hDEAD_BEEF;
        tick(); tick();
        rst_n = 1'b1; add_en = 1'b0;
        // R1: reset state
        check(acc == 32'h0 && drained, "R1 reset state", acc, 32'h0);
        ref_lo = 16'h0; ref_hi = 16'h0;

        // R8: end-around carry in both halves, exact value
        push(32'hFFFF_FFFF);
        push(32'h0001_0001);
        drain_and_check("R8 end-around carry");
        check(acc == 32'h0001_0001, "R8 exact wrap result", acc, 32'h0001_0001);

        // R2: heavy carries in the low half must not reach the high half
        clear_all();
        push(32'h0000_8000);
        push(32'h0000_8000);
        drain_and_check("R2 low carries stay low");
        check(acc == 32'h0000_0001, "R2 high half untouched", acc, 32'h0000_0001);

        // R2: the high half alone, with an all-ones low stream
        clear_all();
        for (int i = 0; i < 5; i++) push(32'h0000_FFFF);
        push(32'h1234_0000);
        drain_and_check("R2 halves independent");
        check(acc[31:16] == 16'h1234, "R2 high half exact", {16'h0, acc[31:16]}, 32'h1234);

        // R4: idle data ignored once settled
        held = acc;
        for (int i = 0; i < 10; i++) gap();
        check(acc == held && drained, "R4 idle data ignored", acc, held);

        // R9: clear during an active add takes priority and empties carries
        push(32'hFFFF_FFFF);
        push(32'hFFFF_FFFF);
        clr = 1'b1; add_en = 1'b1; din = 32'h5555_AAAA;
        tick();
        check(acc == 32'h0 && drained, "R9 clear beats add", acc, 32'h0);
        clr = 1'b0;
        ref_lo = 16'h0; ref_hi = 16'h0;

        // R7: long back-to-back run of all-ones-heavy words
        for (int i = 0; i < 40; i++) push(32'hFFFE_FFFF ^ (i[0] ? 32'h0 : 32'h0001_0000));
        drain_and_check("R7 back-to-back run");

        // R3/R4/R7: random bursts with random gaps
        for (int b = 0; b < 30; b++) begin
            if (b % 7 == 0) clear_all();
            for (int i = 0; i < 1 + ($urandom % 40); i++) begin
                if ($urandom % 4 == 0) gap();
                else push($urandom);
            end
            drain_and_check("R3 random sum");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule